// File: doc/BRIEF.md
# Input Capture Noise Canceler

This block is a digital low-pass filter for one asynchronous capture input. It brings the raw pin into the system clock domain through a short synchronizer. It then samples that level into a four-stage shift chain on a sampling strobe. A new level reaches the filtered output only when every stage of the chain holds the same value. While the stages disagree, the output keeps its last level. Pulses narrower than a few sampling periods therefore never reach the input-capture edge detector that follows.

A two-bit mode register is loaded through a write strobe. It selects one of three sampling rates, or a pass-through mode in which the synchronized pin drives the output directly. The strobes are one-cycle enable pulses taken from a free-running prescaler, so every flop runs on the system clock. Changing the mode leaves the chain contents in place, and filtering carries on at the new rate.

Top module: `cap_noise_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `filt_out` to 0, empties the sample chain to all zeros and sets the mode to 00 (pass-through).
- R2: In mode 00, `filt_out` equals the value `pin_raw` had three clock edges earlier.
- R3: The sampling period P is 2 system clocks in mode 01, 8 in mode 10 and 32 in mode 11. The chain shifts only on a strobe, two strobes never fall on consecutive cycles, and mode 00 has no strobes.
- R4: In a filtering mode, a level held steady on `pin_raw` appears on `filt_out` no later than 4P+3 clock edges after it was applied.
- R5: In a filtering mode, `filt_out` does not take up a new pin level within the first 3P+3 clock edges after that level was applied.
- R6: Starting from a settled input, a pulse of the opposite level that lasts at most 3P clocks leaves `filt_out` unchanged, during the pulse and afterwards.
- R7: In a filtering mode, `filt_out` changes only to a value that all four chain stages agree on. When the stages disagree, `filt_out` holds its level.
- R8: A mode write does not clear the chain. One clock edge after a filtering mode takes effect, an agreeing chain drives its value onto `filt_out`, even if that value differs from the current pin level.
- R9: When `sel_wr` is low, `sel_wdata` has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flops use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 1 | Asynchronous capture pin level |
| sel_wr | input | 1 | Loads `sel_wdata` into the mode register at the clock edge |
| sel_wdata | input | 2 | Mode: 00 pass-through, 01 P=2, 10 P=8, 11 P=32 |
| filt_out | output | 1 | Filtered level to the capture edge detector |

## Verification
In pass-through mode, the bench sets the pin between edges and compares the output three edges later against the pin value it recorded in its own history. In each filtering mode, every pin change is checked twice. At 3P+3 edges the output must still show the old level, because the earliest possible update comes one edge after that. At 4P+4 edges the output must show the new level, which is one edge past the latest bound. A mode write takes effect at the edge on which it is loaded. The bench therefore reads the output one edge later to see the retained chain value, and it adds one spare edge to the settling times of the random episodes.

// File: rtl/cnf_pkg.sv
package cnf_pkg;

   typedef enum logic [1:0] {
      CNF_PASS  = 2'b00,
      CNF_RATEA = 2'b01,
      CNF_RATEB = 2'b10,
      CNF_RATEC = 2'b11
   } cnf_mode_e;

   localparam int CNF_NUM_RATES = 3;

   function automatic int cnf_max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/cnf_sync.sv
module cnf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cnf_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage_q[gi] <= 1'b0;
               else     stage_q[gi] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage_q[gi] <= 1'b0;
               else     stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/cnf_prescale.sv
module cnf_prescale
   import cnf_pkg::*;
#(
   parameter int RATE_A_LOG2 = 1,
   parameter int RATE_B_LOG2 = 3,
   parameter int RATE_C_LOG2 = 5
) (
   input  logic      clk,
   input  logic      rst,
   input  cnf_mode_e mode,
   output logic      strobe
);

   localparam int CNT_W = cnf_max3(RATE_A_LOG2, RATE_B_LOG2, RATE_C_LOG2);
   localparam int RATE_LOG2 [CNF_NUM_RATES] = '{RATE_A_LOG2, RATE_B_LOG2, RATE_C_LOG2};

   generate
      if (RATE_A_LOG2 < 1) begin : g_bad_min
         $error("cnf_prescale: RATE_A_LOG2 must be at least 1");
      end
      if (!(RATE_A_LOG2 < RATE_B_LOG2 && RATE_B_LOG2 < RATE_C_LOG2)) begin : g_bad_order
         $error("cnf_prescale: rates must be strictly increasing");
      end
   endgenerate

   logic [CNT_W-1:0]         cnt_q;
   logic [CNF_NUM_RATES-1:0] tap;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   genvar gr;
   generate
      for (gr = 0; gr < CNF_NUM_RATES; gr++) begin : g_tap
         assign tap[gr] = &cnt_q[RATE_LOG2[gr]-1:0];
      end
   endgenerate

   always_comb begin
      unique case (mode)
         CNF_RATEA: strobe = tap[0];
         CNF_RATEB: strobe = tap[1];
         CNF_RATEC: strobe = tap[2];
         default:   strobe = 1'b0;
      endcase
   end

endmodule

// File: rtl/cnf_vote_chain.sv
module cnf_vote_chain #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             d_in,
   output logic [DEPTH-1:0] chain,
   output logic             all_same
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cnf_vote_chain: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] chain_q;

   genvar gs;
   generate
      for (gs = 0; gs < DEPTH; gs++) begin : g_cell
         if (gs == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)           chain_q[gs] <= 1'b0;
               else if (shift_en) chain_q[gs] <= d_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (rst)           chain_q[gs] <= 1'b0;
               else if (shift_en) chain_q[gs] <= chain_q[gs-1];
            end
         end
      end
   endgenerate

   assign chain    = chain_q;
   assign all_same = (&chain_q) | ~(|chain_q);

endmodule

// File: rtl/cap_noise_filter.sv
module cap_noise_filter
   import cnf_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CHAIN_DEPTH = 4,
   parameter int RATE_A_LOG2 = 1,
   parameter int RATE_B_LOG2 = 3,
   parameter int RATE_C_LOG2 = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pin_raw,
   input  logic       sel_wr,
   input  logic [1:0] sel_wdata,
   output logic       filt_out
);

   cnf_mode_e              sel_q;
   logic                   sync_q;
   logic                   strobe;
   logic [CHAIN_DEPTH-1:0] chain_q;
   logic                   all_same;
   logic                   out_q;

   always_ff @(posedge clk) begin
      if (rst)         sel_q <= CNF_PASS;
      else if (sel_wr) sel_q <= cnf_mode_e'(sel_wdata);
   end

   cnf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (pin_raw),
      .q_sync  (sync_q)
   );

   cnf_prescale #(
      .RATE_A_LOG2 (RATE_A_LOG2),
      .RATE_B_LOG2 (RATE_B_LOG2),
      .RATE_C_LOG2 (RATE_C_LOG2)
   ) u_prescale (
      .clk    (clk),
      .rst    (rst),
      .mode   (sel_q),
      .strobe (strobe)
   );

   cnf_vote_chain #(.DEPTH(CHAIN_DEPTH)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (strobe),
      .d_in     (sync_q),
      .chain    (chain_q),
      .all_same (all_same)
   );

   always_ff @(posedge clk) begin
      if (rst)                    out_q <= 1'b0;
      else if (sel_q == CNF_PASS) out_q <= sync_q;
      else if (all_same)          out_q <= chain_q[0];
   end

   assign filt_out = out_q;

endmodule

// File: rtl/cap_noise_filter_chk.sv
module cap_noise_filter_chk #(
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       sel_q,
   input logic             sync_q,
   input logic             strobe,
   input logic [DEPTH-1:0] chain,
   input logic             all_same,
   input logic             filt_out
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (filt_out == 1'b0 && chain == '0 && sel_q == 2'b00));

   // R2
   pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_q == 2'b00) |=> (filt_out == $past(sync_q)));

   // R3
   chain_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(chain));

   // R3
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   // R3
   pass_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_q == 2'b00) |-> !strobe);

   // R7
   disagree_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_q != 2'b00 && !all_same) |=> $stable(filt_out));

   // R8
   agree_take_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_q != 2'b00 && all_same) |=> (filt_out == $past(chain[0])));

endmodule

bind cap_noise_filter cap_noise_filter_chk #(.DEPTH(CHAIN_DEPTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sel_q    (sel_q),
   .sync_q   (sync_q),
   .strobe   (strobe),
   .chain    (chain_q),
   .all_same (all_same),
   .filt_out (filt_out)
);

// File: tb/cap_noise_filter_tb.sv
module cap_noise_filter_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       pin_raw;
   logic       sel_wr;
   logic [1:0] sel_wdata;
   logic       filt_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   cap_noise_filter u_dut (
      .clk       (clk),
      .rst       (rst),
      .pin_raw   (pin_raw),
      .sel_wr    (sel_wr),
      .sel_wdata (sel_wdata),
      .filt_out  (filt_out)
   );

   function automatic int period_of(input logic [1:0] m);
      case (m)
         2'b01:   return 2;
         2'b10:   return 8;
         2'b11:   return 32;
         default: return 1;
      endcase
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: filt_out=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic chk_cnt(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: count=%0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_mode(input logic [1:0] m);
      sel_wr    = 1'b1;
      sel_wdata = m;
      tick(1);
      sel_wr    = 1'b0;
   endtask

   // settle the input at a level in mode m; the output must then show it (R4)
   task automatic settle(input logic [1:0] m, input logic lvl);
      pin_raw = lvl;
      tick(4 * period_of(m) + 5);
      chk(filt_out, lvl, "R4 settle");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [2:0] hist;
      rst       = 1'b1;
      pin_raw   = 1'b1;
      sel_wr    = 1'b0;
      sel_wdata = 2'b00;
      seed      = $urandom(32'h1c0ffee);
      tick(4);
      rst = 1'b0;
      // R1: output is 0 after reset even with the pin high
      chk(filt_out, 1'b0, "R1 reset level");

      // R2: pass-through mode after reset, three-edge latency
      pin_raw = 1'b0;
      tick(4);
      pin_raw = 1'b1;
      tick(2);
      chk(filt_out, 1'b0, "R2 not before third edge");
      tick(1);
      chk(filt_out, 1'b1, "R2 third edge");

      // R2: random pin pattern in pass-through
      pin_raw = 1'b0;
      tick(4);
      hist = 3'b000;
      for (int i = 0; i < 200; i++) begin
         logic nv;
         chk(filt_out, hist[2], "R2 random follow");
         nv      = 1'($urandom % 2);
         hist    = {hist[1:0], nv};
         pin_raw = nv;
         tick(1);
      end

      // R3 R4 R5: timing window in each filtering mode, both directions
      for (int m = 1; m < 4; m++) begin
         int p;
         p = period_of(2'(m));
         write_mode(2'(m));
         settle(2'(m), 1'b0);
         pin_raw = 1'b1;
         tick(3 * p + 3);
         chk(filt_out, 1'b0, "R5 R3 rise not early");
         tick(p + 1);
         chk(filt_out, 1'b1, "R4 R3 rise by bound");
         pin_raw = 1'b0;
         tick(3 * p + 3);
         chk(filt_out, 1'b1, "R5 R3 fall not early");
         tick(p + 1);
         chk(filt_out, 1'b0, "R4 R3 fall by bound");
      end

      // R6 R7: directed widest rejected pulse in the slowest mode
      write_mode(2'b11);
      settle(2'b11, 1'b0);
      begin
         int bad;
         bad = 0;
         pin_raw = 1'b1;
         for (int c = 0; c < 96; c++) begin
            tick(1);
            if (filt_out !== 1'b0) bad++;
         end
         pin_raw = 1'b0;
         for (int c = 0; c < 4 * 32 + 5; c++) begin
            tick(1);
            if (filt_out !== 1'b0) bad++;
         end
         chk_cnt(bad, 0, "R6 R7 3P pulse rejected");
      end

      // R8: chain kept across pass-through and back
      settle(2'b11, 1'b1);
      write_mode(2'b00);
      pin_raw = 1'b0;
      tick(3);
      chk(filt_out, 1'b0, "R8 pass-through shows low");
      write_mode(2'b01);
      tick(1);
      chk(filt_out, 1'b1, "R8 retained chain restored");
      tick(1);
      chk(filt_out, 1'b1, "R8 held while chain disagrees");
      tick(4 * 2 + 4);
      chk(filt_out, 1'b0, "R8 new level after refill");

      // R9: data without write strobe is ignored
      write_mode(2'b11);
      settle(2'b11, 1'b1);
      sel_wdata = 2'b00;
      sel_wr    = 1'b0;
      pin_raw   = 1'b0;
      tick(5);
      chk(filt_out, 1'b1, "R9 mode unchanged without strobe");
      tick(4 * 32 + 4);
      chk(filt_out, 1'b0, "R9 still filtering at P=32");

      // R4 R6 R7: random episodes of settle and short glitch
      for (int e = 0; e < 30; e++) begin
         logic [1:0] m;
         logic lvl;
         int p;
         int glen;
         int bad;
         m   = 2'(1 + ($urandom % 3));
         lvl = 1'($urandom % 2);
         p   = period_of(m);
         write_mode(m);
         settle(m, lvl);
         glen = 1 + int'($urandom % (3 * p));
         bad  = 0;
         pin_raw = ~lvl;
         for (int c = 0; c < glen; c++) begin
            tick(1);
            if (filt_out !== lvl) bad++;
         end
         pin_raw = lvl;
         for (int c = 0; c < 4 * p + 5; c++) begin
            tick(1);
            if (filt_out !== lvl) bad++;
         end
         chk_cnt(bad, 0, "R6 R7 random glitch rejected");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule